// File: doc/BRIEF.md
# Renaming Reservation Station Array

This block is the scheduling core of an out-of-order floating-point pipeline. Instructions come in program order from an issue queue. Each one is placed in a free reservation station of its class. Stations 1 to NUM_ADD serve the add/subtract unit, and the next NUM_MUL stations serve the multiply/divide unit. Each source operand is taken either as a value from the register file or as the tag of the station that will produce it. Each destination register is renamed to the new station's tag, so later writers and readers of the same register never wait on one another.

A station whose operands are both present is offered to the execution unit of its class. When the unit hands back a result, the station holds it until it wins the single result bus. A won station broadcasts its own tag and value on that bus and frees itself. In the same cycle, every waiting station and every renamed register that names that tag takes the value. The register file and the arithmetic units stay outside the block.

- The register file is read through `iss_val1`/`iss_val2` for the current sources.
- It is written through the `rf_*` port.
- The units talk through the `ex_*` and `done_*` ports, one lane per class.

Top module: `resv_station_array`

## Requirements
- R1: After a synchronous active-low reset, all stations are free and no register has a pending producer. In the first cycle after reset, `iss_ready` is 1 and `cdb_valid`, both `ex_valid` bits and `rf_we` are 0.
- R2: `iss_ready` is 1 exactly when a station of class `iss_class` is free (class 0 = add, tags 1..NUM_ADD; class 1 = mul, tags NUM_ADD+1..NUM_ADD+NUM_MUL). An accepted instruction takes the lowest-numbered free station of its class. Tag 0 means "no producer".
- R3: At issue, a source whose register has no pending producer takes `iss_val1`/`iss_val2`. A source whose producer is broadcasting in that same cycle takes `cdb_value`. Any other source records the producer's tag.
- R4: A waiting station whose recorded tag equals `cdb_tag` while `cdb_valid` is 1 captures `cdb_value` into that operand at that clock edge. All such stations capture in the same cycle.
- R5: Lane c offers a station on `ex_valid[c]` only once both of its operands are present, and no earlier than the cycle after the last one arrived. Among the ready stations of a lane, the lowest tag wins. The station leaves the lane when `ex_valid[c]` and `ex_ready[c]` are both 1, and `ex_a`/`ex_b` carry the first and second source.
- R6: `done_valid[c]` with `done_tag[c]` stores `done_value[c]` in the executing station of that tag. The station may broadcast from the next cycle on.
- R7: At most one station broadcasts per cycle, and it is the lowest-numbered station that holds a result. It drives its own tag and result on `cdb_tag`/`cdb_value`, and it is free and eligible for issue from the next cycle.
- R8: An accepted issue sets the destination register's producer to the new tag, and this overrides a broadcast clearing the same register in the same cycle. During a broadcast, `rf_we` is 1 with `rf_addr`/`rf_data` only for a register whose producer still equals `cdb_tag`.
- R9: After any program has drained, the register file holds the same values as executing the program strictly in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 1 | 0 = add/sub unit, 1 = mul/div unit |
| iss_op | input | OP_W | Operation code passed to the unit |
| iss_dst | input | RIDX_W | Destination register |
| iss_src1 | input | RIDX_W | First source register |
| iss_src2 | input | RIDX_W | Second source register |
| iss_val1 | input | DATA_W | Register file value of `iss_src1` |
| iss_val2 | input | DATA_W | Register file value of `iss_src2` |
| iss_ready | output | 1 | A station of the offered class is free |
| ex_valid | output | 2 | Per lane: a ready station is offered |
| ex_ready | input | 2 | Per lane: the unit accepts the offer |
| ex_tag | output | 2×TAG_W | Per lane: tag of the offered station |
| ex_op | output | 2×OP_W | Per lane: its operation |
| ex_a | output | 2×DATA_W | Per lane: first operand |
| ex_b | output | 2×DATA_W | Per lane: second operand |
| done_valid | input | 2 | Per lane: a result is returned |
| done_tag | input | 2×TAG_W | Per lane: tag the result belongs to |
| done_value | input | 2×DATA_W | Per lane: result value |
| cdb_valid | output | 1 | A result is broadcast this cycle |
| cdb_tag | output | TAG_W | Tag of the broadcasting station |
| cdb_value | output | DATA_W | Broadcast result |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | RIDX_W | Register written |
| rf_data | output | DATA_W | Value written |

## Verification
The bench builds the block with three add stations, two multiply stations, eight registers and 16-bit data. The multiply lane answers three cycles after acceptance and the add lane one cycle after. With so few stations, both classes run full and issue stalls. The eight registers make the random program reuse destinations often, which brings about same-cycle broadcast forwarding at issue and stale broadcasts to registers that have since been renamed again. A short directed prologue adds a read-after-write chain, a write-after-read on a register, and an instruction whose destination is also its source.

// File: rtl/rsa_pkg.sv
// Package rsa_pkg
// Shared types and constants for the reservation station array.
// Assumes exactly two execution lanes: lane 0 add/sub, lane 1 mul/div.
package rsa_pkg;

    localparam int NUM_CLASSES = 2;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_state_e;

endpackage

// File: rtl/rsa_pick.sv
// Module rsa_pick
// Fixed-priority picker: the lowest set request bit wins.
// Assumes IDX_W is wide enough to hold N-1.
module rsa_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top down so that the lowest requester is written last.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsa_station.sv
// Module rsa_station
// One reservation station. It moves through free, waiting, executing and
// done. While waiting it snoops the result bus for its operand tags.
// Assumes alloc is raised only while free, launch only while ready,
// and retire only while done.
module rsa_station
    import rsa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 2,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_qj,
    input  logic [DATA_W-1:0] alloc_vj,
    input  logic [TAG_W-1:0]  alloc_qk,
    input  logic [DATA_W-1:0] alloc_vk,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              launch,
    input  logic              finish,
    input  logic [DATA_W-1:0] finish_value,
    input  logic              retire,
    output logic              is_free,
    output logic              is_ready,
    output logic              is_done,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [DATA_W-1:0] result
);

    st_state_e        state;
    logic [TAG_W-1:0] qj;
    logic [TAG_W-1:0] qk;
    logic             wake_j;
    logic             wake_k;

    // Match the broadcast tag against each pending operand tag.
    always_comb begin
        wake_j = cdb_valid && (qj != '0) && (cdb_tag == qj);
        wake_k = cdb_valid && (qk != '0) && (cdb_tag == qk);
    end

    // Status flags seen by the pickers.
    always_comb begin
        is_free  = (state == ST_FREE);
        is_ready = (state == ST_WAIT) && (qj == '0) && (qk == '0);
        is_done  = (state == ST_DONE);
    end

    // Station state and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FREE;
            op     <= '0;
            qj     <= '0;
            qk     <= '0;
            vj     <= '0;
            vk     <= '0;
            result <= '0;
        end else begin
            unique case (state)
                ST_FREE: begin
                    if (alloc) begin
                        state <= ST_WAIT;
                        op    <= alloc_op;
                        qj    <= alloc_qj;
                        vj    <= alloc_vj;
                        qk    <= alloc_qk;
                        vk    <= alloc_vk;
                    end
                end
                ST_WAIT: begin
                    if (wake_j) begin
                        vj <= cdb_value;
                        qj <= '0;
                    end
                    if (wake_k) begin
                        vk <= cdb_value;
                        qk <= '0;
                    end
                    if (launch) begin
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (finish) begin
                        result <= finish_value;
                        state  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (retire) begin
                        state <= ST_FREE;
                    end
                end
                default: state <= ST_FREE;
            endcase
        end
    end

endmodule

// File: rtl/rsa_reg_status.sv
// Module rsa_reg_status
// Register result status table: one producer tag per architectural
// register, where zero means the register file value is current. It also
// derives the register file write from the result bus.
// Assumes a tag names the destination of at most one register.
module rsa_reg_status #(
    parameter int NUM_REGS = 8,
    parameter int RIDX_W   = 3,
    parameter int TAG_W    = 3,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd1_idx,
    input  logic [RIDX_W-1:0] rd2_idx,
    output logic [TAG_W-1:0]  rd1_tag,
    output logic [TAG_W-1:0]  rd2_tag,
    input  logic              set_en,
    input  logic [RIDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_data
);

    logic [NUM_REGS-1:0][TAG_W-1:0] qi;
    logic [NUM_REGS-1:0]            hit;

    // Producer lookup for the two sources of the issuing instruction.
    always_comb begin
        rd1_tag = qi[rd1_idx];
        rd2_tag = qi[rd2_idx];
    end

    // Registers whose pending producer is broadcasting now.
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            hit[r] = cdb_valid && (qi[r] != '0) && (qi[r] == cdb_tag);
        end
    end

    // Pick the (single) matching register for the write port.
    always_comb begin
        wb_en   = 1'b0;
        wb_idx  = '0;
        wb_data = cdb_value;
        for (int r = NUM_REGS - 1; r >= 0; r--) begin
            if (hit[r]) begin
                wb_en  = 1'b1;
                wb_idx = RIDX_W'(r);
            end
        end
    end

    // Rename at issue; release on a matching broadcast. Issue takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qi <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (set_en && (set_idx == RIDX_W'(r))) begin
                    qi[r] <= set_tag;
                end else if (hit[r]) begin
                    qi[r] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/resv_station_array.sv
// Module resv_station_array
// Reservation stations for two execution lanes, with a register status
// table and a fixed-priority result bus arbiter. Stations 1..NUM_ADD feed
// lane 0 and the next NUM_MUL stations feed lane 1. An instruction issues
// into the lowest free station of its class. Each lane dispatches its lowest
// ready station, and the lowest finished station broadcasts.
// Assumes the register file outside supplies the current values of the
// issuing sources, and each unit returns a tag it was given on its lane.
module resv_station_array
    import rsa_pkg::*;
#(
    parameter int NUM_ADD  = 3,
    parameter int NUM_MUL  = 2,
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int OP_W     = 2,
    localparam int NUM_RS  = NUM_ADD + NUM_MUL,
    localparam int TAG_W   = $clog2(NUM_RS + 1),
    localparam int RIDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                iss_valid,
    input  logic                                iss_class,
    input  logic [OP_W-1:0]                     iss_op,
    input  logic [RIDX_W-1:0]                   iss_dst,
    input  logic [RIDX_W-1:0]                   iss_src1,
    input  logic [RIDX_W-1:0]                   iss_src2,
    input  logic [DATA_W-1:0]                   iss_val1,
    input  logic [DATA_W-1:0]                   iss_val2,
    output logic                                iss_ready,
    output logic [NUM_CLASSES-1:0]              ex_valid,
    input  logic [NUM_CLASSES-1:0]              ex_ready,
    output logic [NUM_CLASSES-1:0][TAG_W-1:0]   ex_tag,
    output logic [NUM_CLASSES-1:0][OP_W-1:0]    ex_op,
    output logic [NUM_CLASSES-1:0][DATA_W-1:0]  ex_a,
    output logic [NUM_CLASSES-1:0][DATA_W-1:0]  ex_b,
    input  logic [NUM_CLASSES-1:0]              done_valid,
    input  logic [NUM_CLASSES-1:0][TAG_W-1:0]   done_tag,
    input  logic [NUM_CLASSES-1:0][DATA_W-1:0]  done_value,
    output logic                                cdb_valid,
    output logic [TAG_W-1:0]                    cdb_tag,
    output logic [DATA_W-1:0]                   cdb_value,
    output logic                                rf_we,
    output logic [RIDX_W-1:0]                   rf_addr,
    output logic [DATA_W-1:0]                   rf_data
);

    localparam logic [NUM_RS-1:0] MASK_ADD = NUM_RS'((64'd1 << NUM_ADD) - 64'd1);
    localparam logic [NUM_RS-1:0] MASK_MUL = ~MASK_ADD;

    // Station-side vectors.
    logic [NUM_RS-1:0]              st_free;
    logic [NUM_RS-1:0]              st_ready;
    logic [NUM_RS-1:0]              st_done;
    logic [NUM_RS-1:0]              st_alloc;
    logic [NUM_RS-1:0]              st_launch;
    logic [NUM_RS-1:0]              st_finish;
    logic [NUM_RS-1:0][OP_W-1:0]    st_op;
    logic [NUM_RS-1:0][DATA_W-1:0]  st_vj;
    logic [NUM_RS-1:0][DATA_W-1:0]  st_vk;
    logic [NUM_RS-1:0][DATA_W-1:0]  st_res;

    // Issue-side signals.
    logic [NUM_RS-1:0]  iss_req;
    logic [NUM_RS-1:0]  iss_gnt;
    logic [TAG_W-1:0]   iss_idx;
    logic               iss_any;
    logic               iss_fire;
    logic [TAG_W-1:0]   iss_tag;
    logic [TAG_W-1:0]   src1_q;
    logic [TAG_W-1:0]   src2_q;
    logic [TAG_W-1:0]   op1_q;
    logic [TAG_W-1:0]   op2_q;
    logic [DATA_W-1:0]  op1_v;
    logic [DATA_W-1:0]  op2_v;

    // Result bus arbitration signals.
    logic [NUM_RS-1:0]  cdb_gnt;
    logic [TAG_W-1:0]   cdb_idx;

    // Per-lane dispatch grants.
    logic [NUM_CLASSES-1:0][NUM_RS-1:0] disp_gnt;
    logic [NUM_CLASSES-1:0][TAG_W-1:0]  disp_idx;

    // Free-station request restricted to the offered class.
    always_comb begin
        iss_req = st_free & (iss_class ? MASK_MUL : MASK_ADD);
    end

    rsa_pick #(.N(NUM_RS), .IDX_W(TAG_W)) u_issue_pick (
        .req (iss_req),
        .gnt (iss_gnt),
        .idx (iss_idx),
        .any (iss_any)
    );

    // Issue handshake and the tag given to the new station.
    always_comb begin
        iss_ready = iss_any;
        iss_fire  = iss_valid && iss_any;
        iss_tag   = iss_idx + TAG_W'(1);
        st_alloc  = iss_fire ? iss_gnt : '0;
    end

    rsa_reg_status #(
        .NUM_REGS (NUM_REGS),
        .RIDX_W   (RIDX_W),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W)
    ) u_reg_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd1_idx   (iss_src1),
        .rd2_idx   (iss_src2),
        .rd1_tag   (src1_q),
        .rd2_tag   (src2_q),
        .set_en    (iss_fire),
        .set_idx   (iss_dst),
        .set_tag   (iss_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .wb_en     (rf_we),
        .wb_idx    (rf_addr),
        .wb_data   (rf_data)
    );

    // Resolve each source: register value, same-cycle broadcast, or tag.
    always_comb begin
        if (src1_q == '0) begin
            op1_q = '0;
            op1_v = iss_val1;
        end else if (cdb_valid && (cdb_tag == src1_q)) begin
            op1_q = '0;
            op1_v = cdb_value;
        end else begin
            op1_q = src1_q;
            op1_v = '0;
        end
        if (src2_q == '0) begin
            op2_q = '0;
            op2_v = iss_val2;
        end else if (cdb_valid && (cdb_tag == src2_q)) begin
            op2_q = '0;
            op2_v = cdb_value;
        end else begin
            op2_q = src2_q;
            op2_v = '0;
        end
    end

    // Station array: class of each station follows from its position.
    for (genvar s = 0; s < NUM_RS; s++) begin : g_station
        localparam int               CLS   = (s < NUM_ADD) ? 0 : 1;
        localparam logic [TAG_W-1:0] MYTAG = TAG_W'(s + 1);

        // Result return and dispatch departure for this station.
        always_comb begin
            st_finish[s] = done_valid[CLS] && (done_tag[CLS] == MYTAG);
            st_launch[s] = ex_valid[CLS] && ex_ready[CLS] && disp_gnt[CLS][s];
        end

        rsa_station #(
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .TAG_W  (TAG_W)
        ) u_station (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc        (st_alloc[s]),
            .alloc_op     (iss_op),
            .alloc_qj     (op1_q),
            .alloc_vj     (op1_v),
            .alloc_qk     (op2_q),
            .alloc_vk     (op2_v),
            .cdb_valid    (cdb_valid),
            .cdb_tag      (cdb_tag),
            .cdb_value    (cdb_value),
            .launch       (st_launch[s]),
            .finish       (st_finish[s]),
            .finish_value (done_value[CLS]),
            .retire       (cdb_gnt[s]),
            .is_free      (st_free[s]),
            .is_ready     (st_ready[s]),
            .is_done      (st_done[s]),
            .op           (st_op[s]),
            .vj           (st_vj[s]),
            .vk           (st_vk[s]),
            .result       (st_res[s])
        );
    end

    // One dispatch picker per execution lane.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lane
        localparam logic [NUM_RS-1:0] LANE_MASK = (c == 0) ? MASK_ADD : MASK_MUL;

        rsa_pick #(.N(NUM_RS), .IDX_W(TAG_W)) u_disp_pick (
            .req (st_ready & LANE_MASK),
            .gnt (disp_gnt[c]),
            .idx (disp_idx[c]),
            .any (ex_valid[c])
        );

        // Present the chosen station's operands to the lane.
        always_comb begin
            ex_tag[c] = disp_idx[c] + TAG_W'(1);
            ex_op[c]  = st_op[disp_idx[c]];
            ex_a[c]   = st_vj[disp_idx[c]];
            ex_b[c]   = st_vk[disp_idx[c]];
        end
    end

    rsa_pick #(.N(NUM_RS), .IDX_W(TAG_W)) u_cdb_pick (
        .req (st_done),
        .gnt (cdb_gnt),
        .idx (cdb_idx),
        .any (cdb_valid)
    );

    // Drive the result bus from the winning station.
    always_comb begin
        cdb_tag   = cdb_idx + TAG_W'(1);
        cdb_value = st_res[cdb_idx];
    end

endmodule

// File: rtl/rsa_checker.sv
// Module rsa_checker
// Protocol properties of the reservation station array, seen at its ports.
// Attached to every instance of the top through the bind below.
module rsa_checker
    import rsa_pkg::*;
#(
    parameter int NUM_ADD = 3,
    parameter int NUM_RS  = 5,
    parameter int TAG_W   = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              iss_ready,
    input logic [NUM_CLASSES-1:0]            ex_valid,
    input logic [NUM_CLASSES-1:0]            ex_ready,
    input logic [NUM_CLASSES-1:0][TAG_W-1:0] ex_tag,
    input logic                              cdb_valid,
    input logic [TAG_W-1:0]                  cdb_tag,
    input logic                              rf_we
);

    // R1: the cycle after a reset cycle shows an idle, empty array.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!cdb_valid && (ex_valid == '0) && iss_ready && !rf_we));

    // R2: each lane only offers stations of its own class.
    assert_lane0_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid[0] |-> (ex_tag[0] != '0) && (ex_tag[0] <= TAG_W'(NUM_ADD)));
    assert_lane1_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid[1] |-> (ex_tag[1] > TAG_W'(NUM_ADD)) && (ex_tag[1] <= TAG_W'(NUM_RS)));

    // R5: an accepted station is not offered again on the next cycle.
    assert_lane0_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid[0] && ex_ready[0]) |=> !(ex_valid[0] && (ex_tag[0] == $past(ex_tag[0]))));
    assert_lane1_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid[1] && ex_ready[1]) |=> !(ex_valid[1] && (ex_tag[1] == $past(ex_tag[1]))));

    // R7: a broadcast tag is a real station and is not repeated next cycle.
    assert_cdb_tag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0) && (cdb_tag <= TAG_W'(NUM_RS)));
    assert_cdb_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> !(cdb_valid && (cdb_tag == $past(cdb_tag))));

    // R8: the register file is written only during a broadcast.
    assert_rf_needs_cdb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> cdb_valid);

endmodule

bind resv_station_array rsa_checker #(
    .NUM_ADD (NUM_ADD),
    .NUM_RS  (NUM_RS),
    .TAG_W   (TAG_W)
) u_rsa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_ready (iss_ready),
    .ex_valid  (ex_valid),
    .ex_ready  (ex_ready),
    .ex_tag    (ex_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .rf_we     (rf_we)
);

// File: tb/tb_resv_station_array.sv
`timescale 1ns/1ps
// Bench for resv_station_array. A behavioural model (integer arrays, no
// module structure) predicts every output on every cycle. The register file
// and the two execution units are modelled here. The final register file
// is compared with a strictly in-order run of the same program.
module tb_resv_station_array;

    localparam int NA = 3;
    localparam int NM = 2;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int OW = 2;
    localparam int NRS = NA + NM;
    localparam int TW = $clog2(NRS + 1);
    localparam int RW = $clog2(NR);
    localparam int NPROG = 400;
    localparam int LIMIT = 20000;
    localparam int LAT_ADD = 1;
    localparam int LAT_MUL = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 iss_valid = 1'b0;
    logic                 iss_class = 1'b0;
    logic [OW-1:0]        iss_op = '0;
    logic [RW-1:0]        iss_dst = '0;
    logic [RW-1:0]        iss_src1 = '0;
    logic [RW-1:0]        iss_src2 = '0;
    logic [DW-1:0]        iss_val1 = '0;
    logic [DW-1:0]        iss_val2 = '0;
    logic                 iss_ready;
    logic [1:0]           ex_valid;
    logic [1:0]           ex_ready = '0;
    logic [1:0][TW-1:0]   ex_tag;
    logic [1:0][OW-1:0]   ex_op;
    logic [1:0][DW-1:0]   ex_a;
    logic [1:0][DW-1:0]   ex_b;
    logic [1:0]           done_valid = '0;
    logic [1:0][TW-1:0]   done_tag = '0;
    logic [1:0][DW-1:0]   done_value = '0;
    logic                 cdb_valid;
    logic [TW-1:0]        cdb_tag;
    logic [DW-1:0]        cdb_value;
    logic                 rf_we;
    logic [RW-1:0]        rf_addr;
    logic [DW-1:0]        rf_data;

    always #2.5 clk = ~clk;

    resv_station_array #(
        .NUM_ADD (NA), .NUM_MUL (NM), .NUM_REGS (NR), .DATA_W (DW), .OP_W (OW)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .iss_valid (iss_valid), .iss_class (iss_class), .iss_op (iss_op),
        .iss_dst (iss_dst), .iss_src1 (iss_src1), .iss_src2 (iss_src2),
        .iss_val1 (iss_val1), .iss_val2 (iss_val2), .iss_ready (iss_ready),
        .ex_valid (ex_valid), .ex_ready (ex_ready), .ex_tag (ex_tag),
        .ex_op (ex_op), .ex_a (ex_a), .ex_b (ex_b),
        .done_valid (done_valid), .done_tag (done_tag), .done_value (done_value),
        .cdb_valid (cdb_valid), .cdb_tag (cdb_tag), .cdb_value (cdb_value),
        .rf_we (rf_we), .rf_addr (rf_addr), .rf_data (rf_data)
    );

    int n_checks = 0;
    int n_fail = 0;

    // Program and golden state.
    int            p_cls [NPROG];
    int            p_op  [NPROG];
    int            p_dst [NPROG];
    int            p_s1  [NPROG];
    int            p_s2  [NPROG];
    logic [DW-1:0] gold  [NR];
    logic [DW-1:0] tb_rf [NR];

    // Model: 0 free, 1 waiting, 2 executing, 3 done.
    int            m_st  [NRS];
    int            m_op  [NRS];
    int            m_qj  [NRS];
    int            m_qk  [NRS];
    logic [DW-1:0] m_vj  [NRS];
    logic [DW-1:0] m_vk  [NRS];
    logic [DW-1:0] m_res [NRS];
    int            m_rq  [NR];

    // Execution unit models.
    int            u_busy [2];
    int            u_cnt  [2];
    int            u_tag  [2];
    logic [DW-1:0] u_val  [2];

    function automatic logic [DW-1:0] unit_calc(int cls, int op, logic [DW-1:0] a, logic [DW-1:0] b);
        if (cls == 0) begin
            case (op)
                0: return a + b;
                1: return a - b;
                2: return a ^ b;
                default: return a | b;
            endcase
        end
        return DW'(a * b) + DW'(op);
    endfunction

    function automatic int cls_lo(int cls);
        return (cls == 0) ? 0 : NA;
    endfunction

    function automatic int cls_hi(int cls);
        return (cls == 0) ? NA - 1 : NRS - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Register file write from the block's own port.
    always @(posedge clk) begin
        if (rst_n && rf_we) tb_rf[rf_addr] <= rf_data;
    end

    initial begin
        logic [15:0] lf;
        logic [15:0] gap_lf;
        int pc;
        bit drained;
        int cyc;
        int exp_fs;
        int exp_ex [2];
        int exp_cw;
        bit exp_rdy;
        int exp_rf;

        // Directed prologue: dependence chain, WAR on r6, dst == src.
        p_cls[0] = 0; p_op[0] = 0; p_dst[0] = 6; p_s1[0] = 2; p_s2[0] = 0;
        p_cls[1] = 0; p_op[1] = 0; p_dst[1] = 2; p_s1[1] = 3; p_s2[1] = 1;
        p_cls[2] = 1; p_op[2] = 0; p_dst[2] = 0; p_s1[2] = 2; p_s2[2] = 4;
        p_cls[3] = 0; p_op[3] = 1; p_dst[3] = 7; p_s1[3] = 6; p_s2[3] = 2;
        p_cls[4] = 1; p_op[4] = 1; p_dst[4] = 5; p_s1[4] = 0; p_s2[4] = 6;
        p_cls[5] = 0; p_op[5] = 0; p_dst[5] = 6; p_s1[5] = 7; p_s2[5] = 2;
        p_cls[6] = 0; p_op[6] = 0; p_dst[6] = 1; p_s1[6] = 1; p_s2[6] = 1;
        lf = 16'hACE1;
        for (int i = 7; i < NPROG; i++) begin
            for (int k = 0; k < 5; k++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p_cls[i] = int'(lf[0]);
            p_op[i]  = int'(lf[3:2]);
            p_dst[i] = int'(lf[6:4]);
            p_s1[i]  = int'(lf[9:7]);
            p_s2[i]  = int'(lf[12:10]);
        end
        for (int r = 0; r < NR; r++) begin
            gold[r]  = DW'(r * 7 + 3);
            tb_rf[r] = DW'(r * 7 + 3);
            m_rq[r]  = 0;
        end
        for (int i = 0; i < NPROG; i++)
            gold[p_dst[i]] = unit_calc(p_cls[i], p_op[i], gold[p_s1[i]], gold[p_s2[i]]);
        for (int s = 0; s < NRS; s++) begin
            m_st[s] = 0; m_op[s] = 0; m_qj[s] = 0; m_qk[s] = 0;
            m_vj[s] = '0; m_vk[s] = '0; m_res[s] = '0;
        end
        for (int c = 0; c < 2; c++) begin
            u_busy[c] = 0; u_cnt[c] = 0; u_tag[c] = 0; u_val[c] = '0;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: the state right after reset.
        #1;
        chk(iss_ready == 1'b1, "R1", "iss_ready after reset", iss_ready, 1);
        chk(cdb_valid == 1'b0, "R1", "cdb_valid after reset", cdb_valid, 0);
        chk(ex_valid == 2'b00, "R1", "ex_valid after reset", ex_valid, 0);
        chk(rf_we == 1'b0, "R1", "rf_we after reset", rf_we, 0);

        pc = 0;
        gap_lf = 16'h1D0F;
        drained = 1'b0;
        cyc = 0;
        while (!drained && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            // Drive inputs from the unit models and the program.
            for (int c = 0; c < 2; c++) begin
                ex_ready[c]   = (u_busy[c] == 0);
                done_valid[c] = (u_busy[c] != 0) && (u_cnt[c] == 1);
                done_tag[c]   = TW'(u_tag[c]);
                done_value[c] = u_val[c];
            end
            gap_lf = {gap_lf[14:0], gap_lf[15] ^ gap_lf[13] ^ gap_lf[12] ^ gap_lf[10]};
            if (pc < NPROG && (pc < 7 || gap_lf[1:0] != 2'b00)) begin
                iss_valid = 1'b1;
                iss_class = p_cls[pc][0];
                iss_op    = OW'(p_op[pc]);
                iss_dst   = RW'(p_dst[pc]);
                iss_src1  = RW'(p_s1[pc]);
                iss_src2  = RW'(p_s2[pc]);
                iss_val1  = tb_rf[p_s1[pc]];
                iss_val2  = tb_rf[p_s2[pc]];
            end else begin
                iss_valid = 1'b0;
            end
            #1;

            // Model predictions for this cycle.
            exp_fs = -1;
            for (int s = cls_hi(int'(iss_class)); s >= cls_lo(int'(iss_class)); s--)
                if (m_st[s] == 0) exp_fs = s;
            exp_rdy = (exp_fs >= 0);
            for (int c = 0; c < 2; c++) begin
                exp_ex[c] = -1;
                for (int s = cls_hi(c); s >= cls_lo(c); s--)
                    if (m_st[s] == 1 && m_qj[s] == 0 && m_qk[s] == 0) exp_ex[c] = s;
            end
            exp_cw = -1;
            for (int s = NRS - 1; s >= 0; s--)
                if (m_st[s] == 3) exp_cw = s;
            exp_rf = -1;
            if (exp_cw >= 0)
                for (int r = 0; r < NR; r++)
                    if (m_rq[r] == exp_cw + 1) exp_rf = r;

            // R2: free-station availability for the offered class.
            chk(iss_ready == exp_rdy, "R2", "iss_ready", iss_ready, exp_rdy);
            // R5, R3, R4: dispatch choice and captured operands.
            for (int c = 0; c < 2; c++) begin
                chk(ex_valid[c] == (exp_ex[c] >= 0), "R5", "ex_valid", ex_valid[c], exp_ex[c] >= 0);
                if (exp_ex[c] >= 0 && ex_valid[c]) begin
                    chk(ex_tag[c] == TW'(exp_ex[c] + 1), "R5", "ex_tag", ex_tag[c], exp_ex[c] + 1);
                    chk(ex_op[c] == OW'(m_op[exp_ex[c]]), "R5", "ex_op", ex_op[c], m_op[exp_ex[c]]);
                    chk(ex_a[c] == m_vj[exp_ex[c]], "R3 R4", "ex_a", ex_a[c], m_vj[exp_ex[c]]);
                    chk(ex_b[c] == m_vk[exp_ex[c]], "R3 R4", "ex_b", ex_b[c], m_vk[exp_ex[c]]);
                end
            end
            // R7, R6: broadcast winner and the stored result.
            chk(cdb_valid == (exp_cw >= 0), "R7", "cdb_valid", cdb_valid, exp_cw >= 0);
            if (exp_cw >= 0 && cdb_valid) begin
                chk(cdb_tag == TW'(exp_cw + 1), "R7", "cdb_tag", cdb_tag, exp_cw + 1);
                chk(cdb_value == m_res[exp_cw], "R6", "cdb_value", cdb_value, m_res[exp_cw]);
            end
            // R8: register write only where the producer still matches.
            chk(rf_we == (exp_rf >= 0), "R8", "rf_we", rf_we, exp_rf >= 0);
            if (exp_rf >= 0 && rf_we) begin
                chk(rf_addr == RW'(exp_rf), "R8", "rf_addr", rf_addr, exp_rf);
                chk(rf_data == m_res[exp_cw], "R8", "rf_data", rf_data, m_res[exp_cw]);
            end

            // Model state after the coming clock edge.
            for (int s = 0; s < NRS; s++) begin
                int cls;
                cls = (s < NA) ? 0 : 1;
                case (m_st[s])
                    1: begin
                        if (exp_cw >= 0 && m_qj[s] == exp_cw + 1) begin
                            m_vj[s] = m_res[exp_cw]; m_qj[s] = 0;
                        end
                        if (exp_cw >= 0 && m_qk[s] == exp_cw + 1) begin
                            m_vk[s] = m_res[exp_cw]; m_qk[s] = 0;
                        end
                        if (exp_ex[cls] == s && ex_ready[cls]) m_st[s] = 2;
                    end
                    2: begin
                        if (done_valid[cls] && int'(done_tag[cls]) == s + 1) begin
                            m_res[s] = done_value[cls]; m_st[s] = 3;
                        end
                    end
                    3: if (s == exp_cw) m_st[s] = 0;
                    default: ;
                endcase
            end
            if (iss_valid && exp_rdy) begin
                int q1;
                int q2;
                q1 = m_rq[int'(iss_src1)];
                q2 = m_rq[int'(iss_src2)];
                m_st[exp_fs] = 1;
                m_op[exp_fs] = int'(iss_op);
                if (q1 == 0) begin m_qj[exp_fs] = 0; m_vj[exp_fs] = iss_val1; end
                else if (exp_cw >= 0 && q1 == exp_cw + 1) begin m_qj[exp_fs] = 0; m_vj[exp_fs] = m_res[exp_cw]; end
                else begin m_qj[exp_fs] = q1; m_vj[exp_fs] = '0; end
                if (q2 == 0) begin m_qk[exp_fs] = 0; m_vk[exp_fs] = iss_val2; end
                else if (exp_cw >= 0 && q2 == exp_cw + 1) begin m_qk[exp_fs] = 0; m_vk[exp_fs] = m_res[exp_cw]; end
                else begin m_qk[exp_fs] = q2; m_vk[exp_fs] = '0; end
            end
            for (int r = 0; r < NR; r++) begin
                if (iss_valid && exp_rdy && int'(iss_dst) == r) m_rq[r] = exp_fs + 1;
                else if (exp_cw >= 0 && m_rq[r] == exp_cw + 1) m_rq[r] = 0;
            end
            for (int c = 0; c < 2; c++) begin
                if (u_busy[c] != 0) begin
                    if (u_cnt[c] == 1) u_busy[c] = 0;
                    else u_cnt[c]--;
                end
                if (exp_ex[c] >= 0 && ex_ready[c]) begin
                    u_busy[c] = 1;
                    u_cnt[c]  = (c == 0) ? LAT_ADD : LAT_MUL;
                    u_tag[c]  = exp_ex[c] + 1;
                    u_val[c]  = unit_calc(c, m_op[exp_ex[c]], m_vj[exp_ex[c]], m_vk[exp_ex[c]]);
                end
            end
            if (iss_valid && exp_rdy) pc++;

            drained = (pc == NPROG) && (u_busy[0] == 0) && (u_busy[1] == 0);
            for (int s = 0; s < NRS; s++)
                if (m_st[s] != 0) drained = 1'b0;
        end

        // Watchdog: the program must drain within the cycle limit.
        chk(drained, "R9", "program drained (watchdog)", drained, 1);
        iss_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R9: architectural state equals in-order execution.
        for (int r = 0; r < NR; r++)
            chk(tb_rf[r] == gold[r], "R9", $sformatf("final r%0d", r), tb_rf[r], gold[r]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule